// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register-and-ALU half of a simple processor in which every storage element (eight general registers, the program counter, the memory address and data registers, the instruction register, an operand staging register Y and a result register Z) meets on one shared internal bus. An external control unit steps the datapath by raising, each cycle, one drive enable that selects what sits on the bus, and any number of load enables that capture the bus on the next rising clock edge.

The ALU takes its first operand from a selector that chooses between the Y register and a fixed constant of four, and takes its second operand straight from the bus. Its result is always parked in Z, and Z is then placed on the bus in a later cycle. The memory-side register exchanges data with external memory: it captures read data once the memory signals completion, and its content is always presented as write data. The address register is always presented as the memory address, and the read and write strobes are registered copies of the controller's requests.

Top module: `sbus_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, all registers clear; afterwards `mem_addr`, `mem_wdata`, `ir_word`, `mem_rd` and `mem_wr` read zero.
- R2: The memory data register loads `mem_rdata` at an edge where `mdr_load_mem` and `mem_mfc` are both high, loads the bus at an edge where `mdr_load_bus` is high, and otherwise holds; `mdr_load_mem` without `mem_mfc` leaves it unchanged. The two load enables are never high together.
- R3: General register k (bit k of `gpr_load`/`gpr_drive`) captures the bus at an edge where its load bit is high, holds otherwise, and supplies the bus while its drive bit is high.
- R4: The bus carries the value of the one source whose drive enable is high, or zero when no drive enable is high; at most one drive enable is high in any cycle.
- R5: ALU operand A is the constant 4 while `sel_const` is 1 and the Y register while it is 0; Y loads from the bus when `y_load` is high; operand B is the bus.
- R6: `alu_op` codes: 0 gives A+B, 1 gives A-B, 2 gives A AND B, 3 gives A OR B, 4 gives B; codes 5 to 7 give zero (all modulo 2^W).
- R7: Z captures the ALU result only at an edge where `z_load` is high and reaches the bus only while `z_drive` is high.
- R8: The instruction register loads from the bus when `ir_load` is high, holds otherwise, is visible on `ir_word`, and supplies the bus while `ir_drive` is high.
- R9: `mem_rd` and `mem_wr` equal `rd_req` and `wr_req` as sampled at the previous rising edge.
- R10: `mem_addr` shows the address register, which loads the bus when `mar_load` is high; `mem_wdata` shows the memory data register.
- R11: When several load enables are high in the same cycle, every selected register captures the same bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| gpr_load | input | NREG | Per-register load-from-bus enables |
| gpr_drive | input | NREG | Per-register drive-bus enables |
| pc_load | input | 1 | Program counter loads the bus |
| pc_drive | input | 1 | Program counter drives the bus |
| mar_load | input | 1 | Address register loads the bus |
| mdr_load_bus | input | 1 | Data register loads the bus |
| mdr_load_mem | input | 1 | Data register loads memory read data (with `mem_mfc`) |
| mdr_drive_bus | input | 1 | Data register drives the bus |
| ir_load | input | 1 | Instruction register loads the bus |
| ir_drive | input | 1 | Instruction register drives the bus |
| y_load | input | 1 | Y register loads the bus |
| sel_const | input | 1 | 1 selects constant 4 as ALU operand A, 0 selects Y |
| alu_op | input | 3 | ALU operation code |
| z_load | input | 1 | Z captures the ALU result |
| z_drive | input | 1 | Z drives the bus |
| rd_req | input | 1 | Read request from the controller |
| wr_req | input | 1 | Write request from the controller |
| mem_rdata | input | W | Memory read data |
| mem_mfc | input | 1 | Memory function complete |
| mem_addr | output | W | Memory address (address register) |
| mem_wdata | output | W | Memory write data (data register) |
| mem_rd | output | 1 | Registered read strobe |
| mem_wr | output | 1 | Registered write strobe |
| ir_word | output | W | Instruction register contents |

## Verification
The hardest state to reach from the ports is a general register or Z holding a chosen value, since nothing writes them except the bus and no port reads them back. The stimulus therefore injects each value through the memory data register (memory data plus completion), copies it across the bus into the target, and reads it out by driving it onto the bus into the address register, where `mem_addr` exposes it. ALU results and the constant-four increment path are observed the same way, two cycles after the operands are staged.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_PASSB = 3'd4
  } alu_op_e;

  localparam int unsigned INC_STEP = 4;
  localparam int unsigned BUS_SRCS = 5;  // gpr group, pc, mdr, ir, z
endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int W    = 32,
  parameter int NREG = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] we,
  input  logic [NREG-1:0] oe,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    rdata
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    for (int k = 0; k < NREG; k++) begin
      if (rst)        regs[k] <= '0;
      else if (we[k]) regs[k] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NREG; k++) begin
      rdata = rdata | (regs[k] & {W{oe[k]}});
    end
  end
endmodule

// File: rtl/sbus_busmux.sv
module sbus_busmux #(
  parameter int W    = 32,
  parameter int NSRC = 5
) (
  input  logic [NSRC-1:0]        sel,
  input  logic [NSRC-1:0][W-1:0] src,
  output logic [W-1:0]           bus
);
  always_comb begin
    bus = '0;
    for (int k = 0; k < NSRC; k++) begin
      bus = bus | (src[k] & {W{sel[k]}});
    end
  end
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2:0]   op,
  input  logic         use_const,
  input  logic [W-1:0] y_val,
  input  logic [W-1:0] b_val,
  output logic [W-1:0] result
);
  logic [W-1:0] a_val;

  assign a_val = use_const ? W'(INC_STEP) : y_val;

  always_comb begin
    case (alu_op_e'(op))
      OP_ADD:   result = a_val + b_val;
      OP_SUB:   result = a_val - b_val;
      OP_AND:   result = a_val & b_val;
      OP_OR:    result = a_val | b_val;
      OP_PASSB: result = b_val;
      default:  result = '0;
    endcase
  end
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter int W    = 32,
  parameter int NREG = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] gpr_load,
  input  logic [NREG-1:0] gpr_drive,
  input  logic            pc_load,
  input  logic            pc_drive,
  input  logic            mar_load,
  input  logic            mdr_load_bus,
  input  logic            mdr_load_mem,
  input  logic            mdr_drive_bus,
  input  logic            ir_load,
  input  logic            ir_drive,
  input  logic            y_load,
  input  logic            sel_const,
  input  logic [2:0]      alu_op,
  input  logic            z_load,
  input  logic            z_drive,
  input  logic            rd_req,
  input  logic            wr_req,
  input  logic [W-1:0]    mem_rdata,
  input  logic            mem_mfc,
  output logic [W-1:0]    mem_addr,
  output logic [W-1:0]    mem_wdata,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [W-1:0]    ir_word
);
  localparam int NSRC = BUS_SRCS;

  logic [W-1:0] pc_q, mar_q, mdr_q, ir_q, y_q, z_q;
  logic [W-1:0] gpr_rd, alu_res, bus_val;
  logic [NSRC-1:0]        bus_sel;
  logic [NSRC-1:0][W-1:0] bus_src;

  sbus_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (gpr_load),
    .oe    (gpr_drive),
    .wdata (bus_val),
    .rdata (gpr_rd)
  );

  assign bus_sel = {z_drive, ir_drive, mdr_drive_bus, pc_drive, |gpr_drive};
  assign bus_src[0] = gpr_rd;
  assign bus_src[1] = pc_q;
  assign bus_src[2] = mdr_q;
  assign bus_src[3] = ir_q;
  assign bus_src[4] = z_q;

  sbus_busmux #(.W(W), .NSRC(NSRC)) u_bus (
    .sel (bus_sel),
    .src (bus_src),
    .bus (bus_val)
  );

  sbus_alu #(.W(W)) u_alu (
    .op        (alu_op),
    .use_const (sel_const),
    .y_val     (y_q),
    .b_val     (bus_val),
    .result    (alu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      mar_q  <= '0;
      mdr_q  <= '0;
      ir_q   <= '0;
      y_q    <= '0;
      z_q    <= '0;
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
    end else begin
      if (pc_load)                      pc_q  <= bus_val;
      if (mar_load)                     mar_q <= bus_val;
      if (mdr_load_bus)                 mdr_q <= bus_val;
      else if (mdr_load_mem && mem_mfc) mdr_q <= mem_rdata;
      if (ir_load)                      ir_q  <= bus_val;
      if (y_load)                       y_q   <= bus_val;
      if (z_load)                       z_q   <= alu_res;
      mem_rd <= rd_req;
      mem_wr <= wr_req;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign ir_word   = ir_q;
endmodule

// File: rtl/sbus_checker.sv
module sbus_checker #(
  parameter int W    = 32,
  parameter int NREG = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [NREG-1:0] gpr_drive,
  input logic            pc_drive,
  input logic            mdr_drive_bus,
  input logic            ir_drive,
  input logic            z_drive,
  input logic            mar_load,
  input logic            mdr_load_bus,
  input logic            mdr_load_mem,
  input logic            mem_mfc,
  input logic [W-1:0]    mem_rdata,
  input logic            ir_load,
  input logic            z_load,
  input logic            rd_req,
  input logic            wr_req,
  input logic [W-1:0]    bus_val,
  input logic [W-1:0]    z_val,
  input logic [W-1:0]    mem_addr,
  input logic [W-1:0]    mem_wdata,
  input logic [W-1:0]    ir_word,
  input logic            mem_rd,
  input logic            mem_wr
);
  p_one_driver_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gpr_drive, pc_drive, mdr_drive_bus, ir_drive, z_drive}));

  p_mdr_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(mdr_load_bus && mdr_load_mem));

  p_mdr_mem_r2: assert property (@(posedge clk) disable iff (rst)
    (mdr_load_mem && mem_mfc && !mdr_load_bus) |=> (mem_wdata == $past(mem_rdata)));

  p_mdr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!mdr_load_bus && !(mdr_load_mem && mem_mfc)) |=> $stable(mem_wdata));

  p_mar_load_r10: assert property (@(posedge clk) disable iff (rst)
    mar_load |=> (mem_addr == $past(bus_val)));

  p_mar_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !mar_load |=> $stable(mem_addr));

  p_ir_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !ir_load |=> $stable(ir_word));

  p_z_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !z_load |=> $stable(z_val));

  p_z_drive_r7: assert property (@(posedge clk) disable iff (rst)
    z_drive |-> (bus_val == z_val));

  p_rd_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (mem_rd == $past(rd_req)));

  p_wr_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (mem_wr == $past(wr_req)));
endmodule

bind sbus_datapath sbus_checker #(.W(W), .NREG(NREG)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .gpr_drive     (gpr_drive),
  .pc_drive      (pc_drive),
  .mdr_drive_bus (mdr_drive_bus),
  .ir_drive      (ir_drive),
  .z_drive       (z_drive),
  .mar_load      (mar_load),
  .mdr_load_bus  (mdr_load_bus),
  .mdr_load_mem  (mdr_load_mem),
  .mem_mfc       (mem_mfc),
  .mem_rdata     (mem_rdata),
  .ir_load       (ir_load),
  .z_load        (z_load),
  .rd_req        (rd_req),
  .wr_req        (wr_req),
  .bus_val       (bus_val),
  .z_val         (z_q),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .ir_word       (ir_word),
  .mem_rd        (mem_rd),
  .mem_wr        (mem_wr)
);

// File: tb/sim_sbus_datapath.sv
`timescale 1ns/1ps
module sim_sbus_datapath;
  localparam int W    = 32;
  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NREG-1:0] gpr_load, gpr_drive;
  logic pc_load, pc_drive, mar_load, mdr_load_bus, mdr_load_mem, mdr_drive_bus;
  logic ir_load, ir_drive, y_load, sel_const, z_load, z_drive, rd_req, wr_req, mem_mfc;
  logic [2:0]   alu_op;
  logic [W-1:0] mem_rdata;
  logic [W-1:0] mem_addr, mem_wdata, ir_word;
  logic mem_rd, mem_wr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  sbus_datapath #(.W(W), .NREG(NREG)) u0 (
    .clk(clk), .rst(rst), .gpr_load(gpr_load), .gpr_drive(gpr_drive),
    .pc_load(pc_load), .pc_drive(pc_drive), .mar_load(mar_load),
    .mdr_load_bus(mdr_load_bus), .mdr_load_mem(mdr_load_mem),
    .mdr_drive_bus(mdr_drive_bus), .ir_load(ir_load), .ir_drive(ir_drive),
    .y_load(y_load), .sel_const(sel_const), .alu_op(alu_op), .z_load(z_load),
    .z_drive(z_drive), .rd_req(rd_req), .wr_req(wr_req), .mem_rdata(mem_rdata),
    .mem_mfc(mem_mfc), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_word(ir_word)
  );

  task automatic idle();
    gpr_load = '0; gpr_drive = '0; pc_load = 0; pc_drive = 0; mar_load = 0;
    mdr_load_bus = 0; mdr_load_mem = 0; mdr_drive_bus = 0; ir_load = 0;
    ir_drive = 0; y_load = 0; sel_const = 0; z_load = 0; z_drive = 0;
    rd_req = 0; wr_req = 0; mem_mfc = 0; alu_op = 3'd0; mem_rdata = '0;
  endtask

  // one clock: controls set before this call are captured at the rising edge
  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mdr_from_mem(input logic [W-1:0] v);
    mdr_load_mem = 1; mem_mfc = 1; mem_rdata = v; tick();
  endtask

  task automatic put_gpr(input int i, input logic [W-1:0] v);
    mdr_from_mem(v);
    mdr_drive_bus = 1; gpr_load[i] = 1; tick();
  endtask

  task automatic read_gpr(input int i, output logic [W-1:0] v);
    gpr_drive[i] = 1; mar_load = 1; tick();
    v = mem_addr;
  endtask

  task automatic t_reset();
    chk("R1 addr", mem_addr, '0);
    chk("R1 wdata", mem_wdata, '0);
    chk("R1 ir", ir_word, '0);
    chk("R1 rd", W'(mem_rd), '0);
    chk("R1 wr", W'(mem_wr), '0);
  endtask

  task automatic t_mdr();
    mdr_load_mem = 1; mem_mfc = 0; mem_rdata = 32'hAAAA_5555; tick();
    chk("R2 no mfc holds", mem_wdata, '0);
    mdr_from_mem(32'hAAAA_5555);
    chk("R2 mem load", mem_wdata, 32'hAAAA_5555);
    tick();
    chk("R2 hold", mem_wdata, 32'hAAAA_5555);
    put_gpr(6, 32'h0BAD_F00D);
    mdr_from_mem(32'h1);
    gpr_drive[6] = 1; mdr_load_bus = 1; tick();
    chk("R2 bus load / R10 wdata", mem_wdata, 32'h0BAD_F00D);
  endtask

  task automatic t_gpr();
    logic [W-1:0] v;
    for (int i = 0; i < NREG; i++) put_gpr(i, 32'h1000_0000 + 32'(i) * 32'h0101_0011);
    for (int i = 0; i < NREG; i++) begin
      read_gpr(i, v);
      chk($sformatf("R3 reg%0d / R10 addr", i), v, 32'h1000_0000 + 32'(i) * 32'h0101_0011);
    end
    put_gpr(2, 32'hCAFE_0002);
    read_gpr(3, v);
    chk("R3 neighbour holds", v, 32'h1303_0033);
    read_gpr(2, v);
    chk("R3 reload", v, 32'hCAFE_0002);
  endtask

  task automatic t_idle_bus();
    logic [W-1:0] v;
    read_gpr(5, v);
    chk("R4 setup", v, 32'h1505_0055);
    mar_load = 1; tick();
    chk("R4 idle bus zero", mem_addr, '0);
  endtask

  task automatic t_multi_load();
    logic [W-1:0] v;
    mdr_from_mem(32'h7777_1234);
    mdr_drive_bus = 1; gpr_load = 8'b1000_0010; ir_load = 1; tick();
    read_gpr(1, v); chk("R11 reg1", v, 32'h7777_1234);
    read_gpr(7, v); chk("R11 reg7", v, 32'h7777_1234);
    chk("R11 ir", ir_word, 32'h7777_1234);
    read_gpr(0, v); chk("R11 reg0 untouched", v, 32'h1000_0000);
  endtask

  task automatic t_pc_inc();
    mdr_from_mem(32'h0000_0100);
    mdr_drive_bus = 1; pc_load = 1; tick();
    pc_drive = 1; sel_const = 1; alu_op = 3'd0; z_load = 1; tick();
    z_drive = 1; pc_load = 1; tick();
    pc_drive = 1; mar_load = 1; tick();
    chk("R5 pc+4", mem_addr, 32'h0000_0104);
  endtask

  task automatic t_alu();
    logic [W-1:0] a, b, exp;
    a = 32'h0F0F_1234; b = 32'h00FF_0F00;
    put_gpr(0, a);
    put_gpr(1, b);
    for (int op = 0; op < 8; op++) begin
      case (op)
        0: exp = a + b;
        1: exp = a - b;
        2: exp = a & b;
        3: exp = a | b;
        4: exp = b;
        default: exp = '0;
      endcase
      gpr_drive[0] = 1; y_load = 1; tick();
      gpr_drive[1] = 1; sel_const = 0; alu_op = 3'(op); z_load = 1; tick();
      z_drive = 1; mar_load = 1; tick();
      chk($sformatf("R6 op%0d (R5 Y operand)", op), mem_addr, exp);
    end
    gpr_drive[1] = 1; sel_const = 1; alu_op = 3'd0; z_load = 1; tick();
    z_drive = 1; mar_load = 1; tick();
    chk("R5 const4+B", mem_addr, b + 32'd4);
  endtask

  task automatic t_z();
    gpr_drive[0] = 1; alu_op = 3'd4; z_load = 1; tick();
    gpr_drive[1] = 1; alu_op = 3'd4; z_load = 0; tick();
    z_drive = 1; mar_load = 1; tick();
    chk("R7 z holds without load", mem_addr, 32'h0F0F_1234);
    mar_load = 1; tick();
    chk("R7 z off bus without drive", mem_addr, '0);
  endtask

  task automatic t_ir();
    mdr_from_mem(32'h8421_0F0F);
    mdr_drive_bus = 1; ir_load = 1; tick();
    chk("R8 ir load", ir_word, 32'h8421_0F0F);
    mdr_from_mem(32'h1111_2222);
    mdr_drive_bus = 1; tick();
    chk("R8 ir holds", ir_word, 32'h8421_0F0F);
    ir_drive = 1; mar_load = 1; tick();
    chk("R8 ir drives bus", mem_addr, 32'h8421_0F0F);
  endtask

  task automatic t_strobe();
    rd_req = 1; #1;
    chk("R9 rd not early", W'(mem_rd), '0);
    tick();
    chk("R9 rd", W'(mem_rd), 1);
    chk("R9 wr idle", W'(mem_wr), 0);
    wr_req = 1; tick();
    chk("R9 rd drop", W'(mem_rd), 0);
    chk("R9 wr", W'(mem_wr), 1);
    tick();
    chk("R9 wr drop", W'(mem_wr), 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_mdr();
    t_gpr();
    t_idle_bus();
    t_multi_load();
    t_pc_inc();
    t_alu();
    t_z();
    t_ir();
    t_strobe();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule